// File: doc/BRIEF.md
# Register File Port Grant Picker

This block decides, every clock, which function units may use the register file's ports. Each function unit raises one bit saying its operands are ready to be read and one bit saying its result is ready to be written. A chain of pickers, one per register file port, turns those request vectors into grants. Each picker selects at most one read unit and at most one write unit. A picker never selects a unit that an earlier picker in the chain has already taken. Because of this, no port is ever contended and no unit is ever served twice in the same cycle.

The grants are held in flip-flops and are wide enough to serve directly as the per-register read and write enables of a flip-flop register file. Each grant therefore stays stable for a whole cycle. The read request vector passes through one extra register before it reaches the pickers. That register breaks the combinational loop that forms when a read grant feeds back into the unit's readiness. As a result, a read grant appears two clock edges after its request, and a write grant appears one edge after its request.

Top module: `port_grant_picker`

## Requirements
- R1: A read grant reflects the read request vector sampled two rising edges earlier. A write grant reflects the write request vector sampled one rising edge earlier.
- R2: Each port's read grant vector and each port's write grant vector has at most one bit set.
- R3: Within one kind, no function unit is granted by more than one port in the same cycle.
- R4: Ports are served in index order, and lower unit indices have priority. Port k grants the requesting unit with the (k+1)-th lowest index. Port k's grant vector occupies bits [k*NUM_FU +: NUM_FU] of the flat output, and bit i of that vector means unit i is granted.
- R5: The number of grants of one kind equals the smaller of the request count and NUM_PORTS. A port whose turn finds no remaining request outputs all zeros.
- R6: When no unit requests, every grant output of that kind is zero.
- R7: Reset clears all grant registers and the delayed read request register. On the first edge after reset is released, read grants are still zero even if read requests were held high throughout reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| readable_i | input | NUM_FU | Per-unit request to read operands |
| writable_i | input | NUM_FU | Per-unit request to write its result |
| go_rd_o | output | NUM_PORTS*NUM_FU | Registered read grants, one NUM_FU-wide one-hot-or-zero slice per port |
| go_wr_o | output | NUM_PORTS*NUM_FU | Registered write grants, one NUM_FU-wide one-hot-or-zero slice per port |

## Verification
In every cycle, the read grants of one request pattern and the write grants of a later, unrelated pattern leave the block together. This is because the two paths have different latencies. The bench streams a new read vector and a new write vector every cycle across all pairs of values. Each cycle it compares the read slices against the pattern from the previous cycle and the write slices against the current one. A design that aligns the two paths, or that lets one kind's mask leak into the other, fails on the first pair in which the two patterns differ.

// File: rtl/port_grant_pkg.sv
package port_grant_pkg;
   // Request latency variants used by the request stage.
   typedef enum int {
      REQ_DIRECT  = 0,
      REQ_DELAYED = 1
   } req_latency_e;
endpackage

// File: rtl/fu_pick_one.sv
module fu_pick_one #(
   parameter int NUM_FU = 16
) (
   input  logic [NUM_FU-1:0] req_i,
   input  logic [NUM_FU-1:0] avail_i,
   output logic [NUM_FU-1:0] gnt_o,
   output logic [NUM_FU-1:0] left_o
);
   logic [NUM_FU-1:0] cand;

   always_comb begin
      cand   = req_i & avail_i;
      gnt_o  = cand & (~cand + NUM_FU'(1));
      left_o = avail_i & ~gnt_o;
   end

   // R2: a single picker grants one unit at most, and only one that asked
   always_comb begin
      a_r2_pick_onehot : assert ($onehot0(gnt_o));
      a_r4_pick_subset : assert ((gnt_o & ~cand) == '0);
   end
endmodule

// File: rtl/fu_pick_chain.sv
module fu_pick_chain #(
   parameter int NUM_FU    = 16,
   parameter int NUM_PORTS = 8
) (
   input  logic [NUM_FU-1:0]           req_i,
   output logic [NUM_PORTS*NUM_FU-1:0] gnt_o
);
   logic [NUM_FU-1:0] avail [NUM_PORTS+1];

   assign avail[0] = '1;

   for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
      fu_pick_one #(.NUM_FU(NUM_FU)) u_pick (
         .req_i  (req_i),
         .avail_i(avail[k]),
         .gnt_o  (gnt_o[k*NUM_FU +: NUM_FU]),
         .left_o (avail[k+1])
      );
   end
endmodule

// File: rtl/req_stage.sv
module req_stage #(
   parameter int                           NUM_FU  = 16,
   parameter port_grant_pkg::req_latency_e LATENCY = port_grant_pkg::REQ_DIRECT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_FU-1:0] req_i,
   output logic [NUM_FU-1:0] req_o
);
   if (LATENCY == port_grant_pkg::REQ_DELAYED) begin : g_delay
      logic [NUM_FU-1:0] req_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) req_q <= '0;
         else        req_q <= req_i;
      end
      assign req_o = req_q;
   end else begin : g_direct
      assign req_o = req_i;
   end
endmodule

// File: rtl/port_grant_picker.sv
module port_grant_picker #(
   parameter int NUM_FU    = 16,
   parameter int NUM_PORTS = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_FU-1:0]           readable_i,
   input  logic [NUM_FU-1:0]           writable_i,
   output logic [NUM_PORTS*NUM_FU-1:0] go_rd_o,
   output logic [NUM_PORTS*NUM_FU-1:0] go_wr_o
);
   import port_grant_pkg::*;

   localparam int GW = NUM_PORTS * NUM_FU;

   if (NUM_FU < 1) begin : g_bad_fu
      $error("port_grant_picker: NUM_FU must be at least 1");
   end
   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("port_grant_picker: NUM_PORTS must be at least 1");
   end

   logic [NUM_FU-1:0] rd_req, wr_req;
   logic [GW-1:0]     rd_pick, wr_pick;

   req_stage #(.NUM_FU(NUM_FU), .LATENCY(REQ_DELAYED)) u_rd_stage (
      .clk(clk), .rst_n(rst_n), .req_i(readable_i), .req_o(rd_req)
   );
   req_stage #(.NUM_FU(NUM_FU), .LATENCY(REQ_DIRECT)) u_wr_stage (
      .clk(clk), .rst_n(rst_n), .req_i(writable_i), .req_o(wr_req)
   );

   fu_pick_chain #(.NUM_FU(NUM_FU), .NUM_PORTS(NUM_PORTS)) u_rd_chain (
      .req_i(rd_req), .gnt_o(rd_pick)
   );
   fu_pick_chain #(.NUM_FU(NUM_FU), .NUM_PORTS(NUM_PORTS)) u_wr_chain (
      .req_i(wr_req), .gnt_o(wr_pick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         go_rd_o <= '0;
         go_wr_o <= '0;
      end else begin
         go_rd_o <= rd_pick;
         go_wr_o <= wr_pick;
      end
   end

   // Union of the per-port slices, used by the checks below.
   logic [NUM_FU-1:0] rd_any, wr_any;
   always_comb begin
      rd_any = '0;
      wr_any = '0;
      for (int k = 0; k < NUM_PORTS; k++) begin
         rd_any |= go_rd_o[k*NUM_FU +: NUM_FU];
         wr_any |= go_wr_o[k*NUM_FU +: NUM_FU];
      end
   end

   for (genvar k = 0; k < NUM_PORTS; k++) begin : g_chk
      a_r2_rd_port_onehot : assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(go_rd_o[k*NUM_FU +: NUM_FU]));
      a_r2_wr_port_onehot : assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(go_wr_o[k*NUM_FU +: NUM_FU]));
   end

   a_r3_rd_disjoint : assert property (@(posedge clk) disable iff (!rst_n)
      $countones(go_rd_o) == $countones(rd_any));
   a_r3_wr_disjoint : assert property (@(posedge clk) disable iff (!rst_n)
      $countones(go_wr_o) == $countones(wr_any));
   a_r1_wr_from_req : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_any & ~$past(writable_i)) == '0);
   a_r1_rd_from_req : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_any & ~$past(readable_i, 2)) == '0);
   a_r6_wr_idle : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(writable_i) == '0) |-> (go_wr_o == '0));
   a_r7_rd_after_reset : assert property (@(posedge clk)
      !rst_n |=> (go_rd_o == '0));
endmodule

// File: tb/port_grant_picker_tb_top.sv
module port_grant_picker_tb_top;
   localparam int FU = 6;
   localparam int P  = 3;
   localparam int GW = FU * P;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [FU-1:0] readable = '0;
   logic [FU-1:0] writable = '0;
   logic [GW-1:0] go_rd, go_wr;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   port_grant_picker #(.NUM_FU(FU), .NUM_PORTS(P)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .readable_i(readable), .writable_i(writable),
      .go_rd_o(go_rd), .go_wr_o(go_wr)
   );

   // Port k takes the (k+1)-th lowest set bit of v.
   function automatic logic [GW-1:0] expect_grants(logic [FU-1:0] v);
      logic [GW-1:0] g = '0;
      int port = 0;
      for (int i = 0; i < FU; i++) begin
         if (v[i] && port < P) begin
            g[port*FU + i] = 1'b1;
            port++;
         end
      end
      return g;
   endfunction

   function automatic int min_int(int a, int b);
      return (a < b) ? a : b;
   endfunction

   task automatic check(string req, logic [GW-1:0] act, logic [GW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_shape(logic [GW-1:0] g, logic [FU-1:0] src, string kind);
      logic [FU-1:0] uni = '0;
      int ones = 0;
      for (int k = 0; k < P; k++) begin
         n_chk++;
         if ($countones(g[k*FU +: FU]) > 1) begin
            n_fail++;
            $display("FAIL R2 %s port %0d actual=%h expected=onehot0", kind, k, g[k*FU +: FU]);
         end
         uni |= g[k*FU +: FU];
         ones += $countones(g[k*FU +: FU]);
      end
      n_chk++;
      if ($countones(uni) != ones) begin
         n_fail++;
         $display("FAIL R3 %s actual=%0d distinct expected=%0d", kind, $countones(uni), ones);
      end
      n_chk++;
      if (ones != min_int($countones(src), P)) begin
         n_fail++;
         $display("FAIL R5 %s actual=%0d grants expected=%0d", kind, ones,
                  min_int($countones(src), P));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [FU-1:0] prev_rd;
      // R7: requests held high through reset
      readable = '1;
      writable = '1;
      repeat (3) @(negedge clk);
      check("R7 rd in reset", go_rd, '0);
      check("R7 wr in reset", go_wr, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R7 rd first edge", go_rd, '0);
      check("R1 wr first edge", go_wr, expect_grants('1));
      prev_rd = '1;

      // Stream every (read, write) pair, one pair per cycle.
      for (int a = 0; a < (1 << FU); a++) begin
         for (int b = 0; b < (1 << FU); b++) begin
            readable = FU'(a);
            writable = FU'(b);
            @(negedge clk);
            check("R1 R4 rd", go_rd, expect_grants(prev_rd));
            check("R1 R4 wr", go_wr, expect_grants(FU'(b)));
            check_shape(go_rd, prev_rd, "rd");
            check_shape(go_wr, FU'(b), "wr");
            if (b == 0) check("R6 wr idle", go_wr, '0);
            if (prev_rd == '0) check("R6 rd idle", go_rd, '0);
            prev_rd = FU'(a);
         end
      end

      // Drain to idle.
      readable = '0;
      writable = '0;
      @(negedge clk);
      @(negedge clk);
      check("R6 rd drained", go_rd, '0);
      check("R6 wr drained", go_wr, '0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule